// File: doc/BRIEF.md
# High-Speed I2C SCL Clock Generator

This block produces the serial clock for an I2C master running in high-speed mode. The high half and the low half of each SCL period each last a programmable number of controller clock cycles. Two 16-bit count registers hold these lengths, so the SCL high time is the high count times the controller clock period. For example, a count of 8 at 125 MHz gives 64 ns.

Software loads the counts through a small write port made of an address, a data word and a write strobe. A read port returns the stored values. The count registers are locked while the generator is enabled. Each register has a lower bound, and a value written below that bound is replaced by the bound.

When enabled, the generator starts SCL in the high state and alternates the two phases. Each return of SCL to high is also marked by a one-cycle pulse, which downstream shift logic can use.

Top module: `hs_scl_gen`

## Requirements
- R1: After reset the high count reads 0x000A, the low count reads 0x0010, `scl_o` is 1 and `scl_rise_o` is 0.
- R2: A write at address 0x24 (high count) or 0x28 (low count) while `en` is 0 stores the data, and the stored value can be read back one cycle later. A read at any other address returns 0.
- R3: A write while `en` is 1 is dropped, and the register keeps its previous value.
- R4: A high count written below 6 is stored as 6.
- R5: A low count written below 8 is stored as 8.
- R6: From the first cycle `en` is sampled as 1, `scl_o` is 1 for exactly the high-count number of cycles, then 0 for exactly the low-count number of cycles, and this period repeats.
- R7: When `en` is sampled as 0, `scl_o` is 1 after that edge. The next enable begins a fresh high phase of the full high count.
- R8: `scl_rise_o` is 1 for exactly the one cycle in which `scl_o` has just gone from 0 to 1. It does not pulse when the generator starts.
- R9: A write to any address other than 0x24 or 0x28 changes neither count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables clock generation and locks the count registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Stored value at `rd_addr` |
| scl_o | output | 1 | SCL drive, 1 means high |
| scl_rise_o | output | 1 | One-cycle pulse after each SCL rising edge |

## Verification
The bench builds the block with its default parameters: 16-bit counts, bounds of 6 and 8, and the addresses listed above. The lower bounds keep the shortest period at 14 cycles, so many complete periods fit into a short run. The bench includes periods made from clamped values, periods from ordinary values, and an enable that drops part-way through a phase. A behavioural model keeps a running cycle index since enable and takes it modulo the period. The model is compared with the design on every clock, and this catches any off-by-one in either phase and any spurious pulse when the generator starts.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_ADDR_W = 8;
endpackage

// File: rtl/scl_cnt_reg.sv
module scl_cnt_reg #(
    parameter int unsigned           CNT_W   = 16,
    parameter int unsigned           ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]     MY_ADDR = '0,
    parameter logic [CNT_W-1:0]      MIN_VAL = 6,
    parameter logic [CNT_W-1:0]      RST_VAL = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  value
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic       hit;

    always_comb begin
        s_d = s_q;
        hit = wr_en && !lock && (wr_addr == MY_ADDR);
        if (hit) begin
            if (wr_data < MIN_VAL) begin
                s_d.val = MIN_VAL;
            end else begin
                s_d.val = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.val <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign value = s_q.val;
endmodule

// File: rtl/scl_period_ctr.sv
module scl_period_ctr
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] lcnt,
    output logic             scl,
    output logic             rise
);
    typedef struct packed {
        logic             run;
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        logic             rise;
    } ctr_state_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ctr_state_t       s_d, s_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        s_d      = s_q;
        s_d.rise = 1'b0;
        limit    = (s_q.phase == PH_HIGH) ? hcnt : lcnt;
        if (!en) begin
            s_d.run   = 1'b0;
            s_d.phase = PH_HIGH;
            s_d.cnt   = '0;
            s_d.scl   = 1'b1;
        end else if (!s_q.run) begin
            s_d.run   = 1'b1;
            s_d.phase = PH_HIGH;
            s_d.cnt   = ONE;
            s_d.scl   = 1'b1;
        end else if (s_q.cnt >= limit) begin
            s_d.cnt = ONE;
            if (s_q.phase == PH_HIGH) begin
                s_d.phase = PH_LOW;
                s_d.scl   = 1'b0;
            end else begin
                s_d.phase = PH_HIGH;
                s_d.scl   = 1'b1;
                s_d.rise  = 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run   <= 1'b0;
            s_q.phase <= PH_HIGH;
            s_q.cnt   <= '0;
            s_q.scl   <= 1'b1;
            s_q.rise  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl  = s_q.scl;
    assign rise = s_q.rise;
endmodule

// File: rtl/hs_scl_gen.sv
module hs_scl_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned           CNT_W   = DEF_CNT_W,
    parameter int unsigned           ADDR_W  = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0]     HI_ADDR = 8'h24,
    parameter logic [ADDR_W-1:0]     LO_ADDR = 8'h28,
    parameter logic [CNT_W-1:0]      HI_MIN  = 6,
    parameter logic [CNT_W-1:0]      LO_MIN  = 8,
    parameter logic [CNT_W-1:0]      HI_RST  = 16'h000A,
    parameter logic [CNT_W-1:0]      LO_RST  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              scl_o,
    output logic              scl_rise_o
);
    localparam int unsigned N_REGS = 2;
    localparam logic [N_REGS*ADDR_W-1:0] ADDRS = {LO_ADDR, HI_ADDR};
    localparam logic [N_REGS*CNT_W-1:0]  MINS  = {LO_MIN, HI_MIN};
    localparam logic [N_REGS*CNT_W-1:0]  RSTS  = {LO_RST, HI_RST};

    logic [CNT_W-1:0] cnt_vals [N_REGS];
    logic [CNT_W-1:0] hcnt_q, lcnt_q;

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        scl_cnt_reg #(
            .CNT_W  (CNT_W),
            .ADDR_W (ADDR_W),
            .MY_ADDR(ADDRS[g*ADDR_W +: ADDR_W]),
            .MIN_VAL(MINS[g*CNT_W +: CNT_W]),
            .RST_VAL(RSTS[g*CNT_W +: CNT_W])
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .lock   (en),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .value  (cnt_vals[g])
        );
    end

    assign hcnt_q = cnt_vals[0];
    assign lcnt_q = cnt_vals[1];

    always_comb begin
        rd_data = '0;
        if (rd_addr == HI_ADDR) begin
            rd_data = hcnt_q;
        end else if (rd_addr == LO_ADDR) begin
            rd_data = lcnt_q;
        end
    end

    scl_period_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .hcnt (hcnt_q),
        .lcnt (lcnt_q),
        .scl  (scl_o),
        .rise (scl_rise_o)
    );
endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk #(
    parameter int unsigned      CNT_W  = 16,
    parameter logic [CNT_W-1:0] HI_MIN = 6,
    parameter logic [CNT_W-1:0] LO_MIN = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             scl_o,
    input logic             scl_rise_o,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] lcnt
);
    // R3: locked registers hold while enabled
    p_hi_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(hcnt));
    p_lo_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(lcnt));
    // R4 / R5: stored values never below bounds
    p_hi_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt >= HI_MIN);
    p_lo_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lcnt >= LO_MIN);
    // R7: disabled means SCL high after the edge
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl_o);
    // R8: pulse only right after a low-to-high transition
    p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |-> (scl_o && !$past(scl_o)));
    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |=> !scl_rise_o);
endmodule

bind hs_scl_gen scl_gen_chk #(
    .CNT_W (CNT_W),
    .HI_MIN(HI_MIN),
    .LO_MIN(LO_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_o     (scl_o),
    .scl_rise_o(scl_rise_o),
    .hcnt      (hcnt_q),
    .lcnt      (lcnt_q)
);

// File: tb/tb_hs_scl_gen.sv
module tb_hs_scl_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h24;
    logic [15:0] rd_data;
    logic        scl_o, scl_rise_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural model state
    int  mh = 10, ml = 16;
    bit  run = 0;
    int  t = 0;
    bit  escl = 1, erise = 0;

    always #4 clk = ~clk; // 125 MHz

    hs_scl_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .scl_o(scl_o), .scl_rise_o(scl_rise_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int model_rd(input logic [7:0] a);
        if (a == 8'h24) return mh;
        if (a == 8'h28) return ml;
        return 0;
    endfunction

    // reference model advances on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mh = 10; ml = 16; run = 0; t = 0; escl = 1; erise = 0;
        end else begin
            cycles++;
            if (en) begin
                if (!run) begin run = 1; t = 0; end
                else t++;
                escl  = ((t % (mh + ml)) < mh);
                erise = ((t % (mh + ml)) == 0) && (t > 0);
            end else begin
                run = 0; t = 0; escl = 1; erise = 0;
            end
            if (wr_en && !en) begin
                if (wr_addr == 8'h24) mh = (wr_data < 6) ? 6 : int'(wr_data);
                if (wr_addr == 8'h28) ml = (wr_data < 8) ? 8 : int'(wr_data);
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 scl_o", int'(scl_o), int'(escl));
            chk("R8 scl_rise_o", int'(scl_rise_o), int'(erise));
            chk("R2 rd_data", int'(rd_data), model_rd(rd_addr));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] a, input int exp);
        @(negedge clk); #1;
        rd_addr = a;
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        step(3);
        // R1: reset state
        chk("R1 scl_o", int'(scl_o), 1);
        chk("R1 scl_rise_o", int'(scl_rise_o), 0);
        rd_expect("R1 hcnt", 8'h24, 10);
        rd_expect("R1 lcnt", 8'h28, 16);
        rst_n = 1'b1;
        step(2);
        // R6: run with default counts
        en = 1'b1;
        step(80);
        // R7: drop enable mid-phase
        en = 1'b0;
        @(negedge clk);
        chk("R7 scl high after disable", int'(scl_o), 1);
        #1;
        // R4, R5: clamping
        wr(8'h24, 16'd3);
        rd_expect("R4 hcnt clamp", 8'h24, 6);
        wr(8'h28, 16'd0);
        rd_expect("R5 lcnt clamp", 8'h28, 8);
        en = 1'b1;
        step(60);
        en = 1'b0;
        step(2);
        // R2: ordinary values, R9: foreign address
        wr(8'h24, 16'd7);
        wr(8'h28, 16'd9);
        wr(8'h2C, 16'd40);
        rd_expect("R2 hcnt", 8'h24, 7);
        rd_expect("R9 hcnt untouched", 8'h24, 7);
        rd_expect("R9 lcnt untouched", 8'h28, 9);
        rd_expect("R2 other addr reads 0", 8'h2C, 0);
        rd_addr = 8'h24;
        en = 1'b1;
        step(5);
        // R3: writes while enabled are dropped
        wr(8'h24, 16'd20);
        wr(8'h28, 16'd30);
        rd_expect("R3 hcnt locked", 8'h24, 7);
        rd_expect("R3 lcnt locked", 8'h28, 9);
        step(50);
        // R7: restart gives fresh full high phase
        en = 1'b0;
        step(1);
        en = 1'b1;
        step(40);
        en = 1'b0;
        step(3);
        finish_run();
    end
endmodule